// File: doc/BRIEF.md
# Host Command Power-Control Decoder

This block sits behind the command register of a slave peripheral controller and turns single-byte host commands into control levels. It recognises two kinds of command. A hand-over command gives one port bit to direct host control. A suspend command drops the device into a micro-power state. Writes arrive as a strobe, a command/data select and a data byte. They are sampled on the rising clock edge. Every output is a register, so it changes one clock after the write is sampled.

The suspend state turns off the oscillator enable and the CPU run enable, and it tristates the port pads. Nothing leaves suspend except reset. The hand-over command makes the chosen port bit a dedicated output that is controlled only by the host. From then on the internal CPU's writes to that bit have no effect. The bit's value can be changed only by a data byte that directly follows the hand-over command. The bit's current value is always visible on an output.

Top module: `pcd_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the outputs are osc_en=1, cpu_run=1, port_hiz=0, pin_dedicated=0 and pin_value=0.
- R2: A command write (wr_stb=1, cmd_sel=1) with byte 0x82 clears osc_en and cpu_run at the next clock edge.
- R3: A command write with byte 0xE2 has the same effect as 0x82.
- R4: While suspended, port_hiz=1. Outside suspend, port_hiz=0.
- R5: While suspended, every command write, data write and CPU pin write is ignored, and every output holds its value. Only reset leaves suspend.
- R6: A command write with byte 0xD1 sets pin_dedicated=1 at the next edge. It stays 1 until reset.
- R7: A data write (wr_stb=1, cmd_sel=0) that immediately follows a 0xD1 command loads pin_value from bit 0 of wr_data. A data write that does not immediately follow 0xD1 leaves pin_value unchanged.
- R8: While pin_dedicated=0, a CPU write (cpu_pin_we=1) loads pin_value from cpu_pin_val at the next edge. While pin_dedicated=1, a CPU write has no effect.
- R9: A command byte other than 0x82, 0xE2 or 0xD1 leaves every output unchanged.
- R10: A command write that directly follows 0xD1 cancels the pending data load and is decoded as an ordinary command. A later data write is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Host write strobe |
| cmd_sel | input | 1 | 1 = command byte, 0 = data byte |
| wr_data | input | 8 | Host write byte |
| cpu_pin_we | input | 1 | Internal CPU write to the hand-over bit |
| cpu_pin_val | input | 1 | Value the CPU writes |
| pin_dedicated | output | 1 | Hand-over bit is under host control |
| pin_value | output | 1 | Current value of the hand-over bit |
| osc_en | output | 1 | Oscillator enable |
| cpu_run | output | 1 | Internal CPU run enable |
| port_hiz | output | 1 | Tristate all port pads |

## Verification
The bench writes all 256 byte values as commands from a fresh reset. This separates the two suspend opcodes and the hand-over opcode from every other byte. It then writes all 256 values again while the block is suspended, as commands, as data and mixed with CPU writes, to show that none of them affects any output. The data load is tried with all 256 data bytes after a hand-over command; the expected pin value is bit 0 of each byte. This is contrasted with data writes that carry no prefix, with a command placed between the prefix and the data, and with CPU writes made before and after the hand-over.

// File: rtl/pcd_pkg.sv
// Package: shared constants and types for the power-control command decoder.
// Assumes 8-bit command bytes; opcode values are fixed by the host protocol.
package pcd_pkg;
    localparam int CMD_W      = 8;
    localparam int N_SUSP_OPS = 2;

    localparam logic [CMD_W-1:0] OP_HANDOVER = 8'hD1;
    localparam logic [CMD_W-1:0] OP_SUSP_A   = 8'h82;
    localparam logic [CMD_W-1:0] OP_SUSP_B   = 8'hE2;

    typedef enum logic [1:0] {
        CK_NONE     = 2'd0,
        CK_SUSPEND  = 2'd1,
        CK_HANDOVER = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic      cmd_fire;   // command strobe this cycle
        logic      data_fire;  // data strobe this cycle
        cmd_kind_e kind;       // decoded kind (valid with cmd_fire)
    } cmd_dec_t;
endpackage

// File: rtl/pcd_cmd_decode.sv
// Module: combinational command classifier.
// Splits a host write into command or data and decodes the command byte into
// one of the known kinds. The suspend opcodes come from a parameter list so that
// more aliases can be added without changing the logic.
module pcd_cmd_decode
    import pcd_pkg::*;
#(
    parameter int                   W       = CMD_W,
    parameter int                   NSUSP   = N_SUSP_OPS,
    parameter logic [NSUSP*W-1:0]   SUSP_OPS = {OP_SUSP_B, OP_SUSP_A},
    parameter logic [W-1:0]         HAND_OP  = OP_HANDOVER
) (
    input  logic         wr_stb,
    input  logic         cmd_sel,
    input  logic [W-1:0] wr_data,
    output cmd_dec_t     dec
);
    logic [NSUSP-1:0] susp_hit;

    // One comparator per suspend opcode alias.
    for (genvar g = 0; g < NSUSP; g++) begin : g_susp_cmp
        assign susp_hit[g] = (wr_data == SUSP_OPS[g*W +: W]);
    end

    // Classify the write and the command byte.
    always_comb begin
        dec.cmd_fire  = wr_stb && cmd_sel;
        dec.data_fire = wr_stb && !cmd_sel;
        if (|susp_hit)
            dec.kind = CK_SUSPEND;
        else if (wr_data == HAND_OP)
            dec.kind = CK_HANDOVER;
        else
            dec.kind = CK_NONE;
    end
endmodule

// File: rtl/pcd_suspend_ctl.sv
// Module: suspend state holder.
// Sets on a suspend command and is cleared only by reset. It drives the
// oscillator, CPU-run and pad-tristate controls from registers.
// Assumes rst_n is synchronous and active low.
module pcd_suspend_ctl
    import pcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_dec_t dec,
    output logic     suspended,
    output logic     osc_en,
    output logic     cpu_run,
    output logic     port_hiz
);
    logic susp_q;

    // Suspend latch: only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            susp_q <= 1'b0;
        else if (dec.cmd_fire && dec.kind == CK_SUSPEND)
            susp_q <= 1'b1;
    end

    // Registered power controls derived from the next suspend state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_en   <= 1'b1;
            cpu_run  <= 1'b1;
            port_hiz <= 1'b0;
        end else if (dec.cmd_fire && dec.kind == CK_SUSPEND) begin
            osc_en   <= 1'b0;
            cpu_run  <= 1'b0;
            port_hiz <= 1'b1;
        end
    end

    assign suspended = susp_q;

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.cmd_fire && dec.kind == CK_SUSPEND) |=> (!osc_en && !cpu_run));
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        susp_q |=> (susp_q && !osc_en && !cpu_run));
    p_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        susp_q |-> port_hiz);
endmodule

// File: rtl/pcd_pin_ctl.sv
// Module: hand-over port bit controller.
// Tracks whether the bit is owned by the host and whether a data load is
// pending after the hand-over opcode. It holds the bit value. Before hand-over,
// the CPU writes the bit; afterwards only the host data byte that follows the
// opcode can. All updates stop while the device is suspended.
module pcd_pin_ctl
    import pcd_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cmd_dec_t     dec,
    input  logic [W-1:0] wr_data,
    input  logic         frozen,
    input  logic         cpu_pin_we,
    input  logic         cpu_pin_val,
    output logic         pin_dedicated,
    output logic         pin_value
);
    logic ded_q, arm_q, pin_q;
    logic data_load;

    assign data_load = arm_q && dec.data_fire && !frozen;

    // Ownership flag: set by the hand-over opcode, kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ded_q <= 1'b0;
        else if (!frozen && dec.cmd_fire && dec.kind == CK_HANDOVER)
            ded_q <= 1'b1;
    end

    // Pending-load flag: armed by the opcode, dropped by any other write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm_q <= 1'b0;
        else if (!frozen && (dec.cmd_fire || dec.data_fire))
            arm_q <= dec.cmd_fire && dec.kind == CK_HANDOVER;
    end

    // Bit value: host data load when owned, CPU write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (frozen)
            pin_q <= pin_q;
        else if (ded_q) begin
            if (data_load)
                pin_q <= wr_data[0];
        end else if (cpu_pin_we)
            pin_q <= cpu_pin_val;
    end

    assign pin_dedicated = ded_q;
    assign pin_value     = pin_q;

    p_ded_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ded_q |=> ded_q);
    p_cpu_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_q && !data_load) |=> $stable(pin_q));
    p_arm_needs_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> ded_q);
    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> ($stable(pin_q) && $stable(arm_q)));
endmodule

// File: rtl/pcd_top.sv
// Module: host command power-control decoder, top level.
// Decodes host writes to the command register, drives the suspend power
// controls and manages the hand-over port bit. Assumes host writes are
// synchronous to clk and rst_n is synchronous and active low.
module pcd_top
    import pcd_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic         cmd_sel,
    input  logic [W-1:0] wr_data,
    input  logic         cpu_pin_we,
    input  logic         cpu_pin_val,
    output logic         pin_dedicated,
    output logic         pin_value,
    output logic         osc_en,
    output logic         cpu_run,
    output logic         port_hiz
);
    cmd_dec_t dec;
    logic     suspended;

    pcd_cmd_decode #(.W(W)) u_dec (
        .wr_stb  (wr_stb),
        .cmd_sel (cmd_sel),
        .wr_data (wr_data),
        .dec     (dec)
    );

    pcd_suspend_ctl u_susp (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .suspended (suspended),
        .osc_en    (osc_en),
        .cpu_run   (cpu_run),
        .port_hiz  (port_hiz)
    );

    pcd_pin_ctl #(.W(W)) u_pin (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec           (dec),
        .wr_data       (wr_data),
        .frozen        (suspended),
        .cpu_pin_we    (cpu_pin_we),
        .cpu_pin_val   (cpu_pin_val),
        .pin_dedicated (pin_dedicated),
        .pin_value     (pin_value)
    );

    p_unknown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cmd_sel && dec.kind == CK_NONE && !cpu_pin_we)
        |=> ($stable(pin_dedicated) && $stable(pin_value) && $stable(osc_en) && $stable(port_hiz)));
    p_e2_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cmd_sel && wr_data == OP_SUSP_B) |=> port_hiz);
endmodule

// File: tb/pcd_top_tb_top.sv
// Testbench: sweeps every byte value through the command and data paths and
// compares the outputs with values derived from the requirements.
module pcd_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0, wr_stb = 1'b0, cmd_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic cpu_pin_we = 1'b0, cpu_pin_val = 1'b0;
    logic pin_dedicated, pin_value, osc_en, cpu_run, port_hiz;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcd_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_sel(cmd_sel),
        .wr_data(wr_data), .cpu_pin_we(cpu_pin_we), .cpu_pin_val(cpu_pin_val),
        .pin_dedicated(pin_dedicated), .pin_value(pin_value),
        .osc_en(osc_en), .cpu_run(cpu_run), .port_hiz(port_hiz)
    );

    // Compare the packed outputs {ded,val,osc,run,hiz} with the expected value.
    task automatic check(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {pin_dedicated, pin_value, osc_en, cpu_run, port_hiz};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_stb = 1'b0; cpu_pin_we = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // One host write, then back at the next negedge with outputs settled.
    task automatic host_wr(input logic is_cmd, input logic [7:0] b);
        wr_stb = 1'b1; cmd_sel = is_cmd; wr_data = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic cpu_wr(input logic v);
        cpu_pin_we = 1'b1; cpu_pin_val = v;
        @(negedge clk); cpu_pin_we = 1'b0;
    endtask

    localparam logic [4:0] IDLE = 5'b00110;
    localparam logic [4:0] SUSP = 5'b00001;
    localparam logic [4:0] DED  = 5'b10110;

    initial begin
        do_reset();
        check("R1 reset", IDLE);

        // Sweep every command byte from a fresh reset (R2, R3, R6, R9).
        for (int b = 0; b < 256; b++) begin
            do_reset();
            host_wr(1'b1, 8'(b));
            if (b == 8'h82)      check("R2 suspend 82", SUSP);
            else if (b == 8'hE2) check("R3 suspend E2 / R4 hiz", SUSP);
            else if (b == 8'hD1) check("R6 handover", DED);
            else                 check("R9 unknown cmd", IDLE);
        end

        // While suspended, all writes are ignored (R5); the pin is readable.
        do_reset();
        cpu_wr(1'b1);
        check("R8 cpu write before handover", 5'b01110);
        host_wr(1'b1, 8'h82);
        for (int b = 0; b < 256; b++) begin
            host_wr(1'b1, 8'(b));
            host_wr(1'b0, 8'(b));
            cpu_wr(b[0]);
            check("R5 ignored in suspend", 5'b01001);
        end
        do_reset();
        check("R5 reset exits suspend", IDLE);

        // Data load after the prefix follows bit 0 (R7).
        for (int b = 0; b < 256; b++) begin
            host_wr(1'b1, 8'hD1);
            host_wr(1'b0, 8'(b));
            check("R7 prefixed load", {1'b1, b[0], 3'b110});
            host_wr(1'b0, ~8'(b));
            check("R7 unprefixed data ignored", {1'b1, b[0], 3'b110});
        end

        // After hand-over, CPU writes do nothing (R8).
        do_reset();
        host_wr(1'b1, 8'hD1);
        cpu_wr(1'b1);
        check("R8 cpu blocked after handover", DED);
        host_wr(1'b0, 8'h01);
        check("R7 load after cpu write", 5'b11110);
        cpu_wr(1'b0);
        check("R8 cpu blocked keeps 1", 5'b11110);

        // Command between prefix and data cancels the load (R10).
        do_reset();
        host_wr(1'b1, 8'hD1);
        host_wr(1'b1, 8'h33);
        host_wr(1'b0, 8'h01);
        check("R10 cancelled by command", DED);
        host_wr(1'b1, 8'hD1);
        host_wr(1'b1, 8'hE2);
        check("R10 suspend after prefix", 5'b10001);
        host_wr(1'b0, 8'h01);
        check("R10 data after suspend", 5'b10001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule